// File: doc/BRIEF.md
# Two-Stage Bilinear Pixel Interpolator

This block turns four neighbouring 8-bit source intensities and two scaled sub-pixel offsets into one interpolated output intensity. It is meant to sit behind a pixel fetcher and a coordinate unit in an image warping pipeline. Each input beat carries the pixels at source positions (u,v), (u+1,v), (u,v+1) and (u+1,v+1), a horizontal offset and a vertical offset, and a flag that marks a source position outside the original image.

The arithmetic uses the difference form of linear interpolation. The first stage blends along the horizontal axis on the upper and lower pixel pairs in parallel. The second stage blends those two results along the vertical axis. The design has only three multipliers in two multiply stages. Valid/ready handshakes sit on both sides. When the output is not stalled, the block accepts one beat per clock. A stall on the output freezes every stage at once.

Top module: `bilerp_pipe`

## Requirements
- R1: While reset is held and straight after it is released, out_valid is 0 and in_ready is 1.
- R2: With the vertical offset at 0, out_pix equals pix_a + floor((pix_b - pix_a) * uf / 2^PU). pix_a is the pixel at (u,v), pix_b is the pixel at (u+1,v), and uf is in_ufrac read as an unsigned integer.
- R3: In general out_pix = t + floor((w - t) * vf / 2^PV), clamped to 0..255. Here t = pix_a + floor((pix_b - pix_a)*uf/2^PU) and w = pix_c + floor((pix_d - pix_c)*uf/2^PU). pix_c is the pixel at (u,v+1) and pix_d is the pixel at (u+1,v+1).
- R4: When both offsets are 0, out_pix equals pix_a exactly, whatever values the other three pixels hold.
- R5: When a difference is negative, each scaled product is rounded toward negative infinity, not toward zero.
- R6: A beat accepted with in_oob = 1 produces out_pix = 0, whatever its pixels and offsets are.
- R7: A beat accepted at a clock edge shows up with out_valid = 1 after the second edge, if no stall comes in between. With out_ready held at 1, a back-to-back stream gives one result on every clock.
- R8: While out_valid = 1 and out_ready = 0, in_ready is 0, and in the next cycle out_valid stays 1 and out_pix keeps its value.
- R9: Results leave in the order their beats were accepted. No beat is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_pix_a | input | 8 | Pixel at (u,v) |
| in_pix_b | input | 8 | Pixel at (u+1,v) |
| in_pix_c | input | 8 | Pixel at (u,v+1) |
| in_pix_d | input | 8 | Pixel at (u+1,v+1) |
| in_ufrac | input | PU | Horizontal offset scaled by 2^PU |
| in_vfrac | input | PV | Vertical offset scaled by 2^PV |
| in_oob | input | 1 | Source position outside the image |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | 8 | Interpolated intensity |

## Verification
Random beats use arbitrary pixels and offsets, with occasional out-of-range flags and random gaps on both handshakes. These beats exercise the full two-axis formula and the ordering under stalls. Directed beats pin down the rest. Zero offsets separate a correct pixel choice from a swapped neighbour. Descending pixel pairs with small offsets separate rounding toward negative infinity from rounding toward zero. A vertical offset of 0 isolates the horizontal stage. Saturated pixels with maximum offsets probe the top of the range. A single beat into an empty pipe and a steady burst measure the latency and the throughput.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;

    // Working width for a difference-form blend: operand, sign, and fraction.
    function automatic int prod_width(input int dw, input int fb);
        return dw + fb + 2;
    endfunction

endpackage

// File: rtl/bilerp_lerp.sv
module bilerp_lerp #(
    parameter int DW = 9,
    parameter int FB = 8
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic        [FB-1:0] frac,
    output logic signed [DW:0]   y
);
    localparam int PW = bilerp_pkg::prod_width(DW, FB);

    logic signed [PW-1:0] a_x, b_x, f_x, d_x, p_x, s_x;

    // y = a + ((b - a) * frac >>> FB), one multiplier per instance
    always_comb begin
        a_x = PW'(a);
        b_x = PW'(b);
        f_x = PW'({1'b0, frac});
        d_x = b_x - a_x;
        p_x = d_x * f_x;
        s_x = a_x + (p_x >>> FB);
        y   = s_x[DW:0];
    end
endmodule

// File: rtl/bilerp_ctrl.sv
module bilerp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic s1_vld,
    output logic s2_vld
);
    // every stage moves together unless the output holds a beat nobody takes
    assign adv = !(s2_vld && !out_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
        end else if (adv) begin
            s1_vld <= in_valid;
            s2_vld <= s1_vld;
        end
    end
endmodule

// File: rtl/bilerp_pipe.sv
module bilerp_pipe #(
    parameter int PIX_W = 8,
    parameter int PU    = 8,
    parameter int PV    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix_a,
    input  logic [PIX_W-1:0] in_pix_b,
    input  logic [PIX_W-1:0] in_pix_c,
    input  logic [PIX_W-1:0] in_pix_d,
    input  logic [PU-1:0]    in_ufrac,
    input  logic [PV-1:0]    in_vfrac,
    input  logic             in_oob,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix
);
    localparam int S0W = PIX_W + 1;
    localparam int S1W = PIX_W + 2;
    localparam int S2W = PIX_W + 3;

    logic adv, s1_vld;

    bilerp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .adv       (adv),
        .s1_vld    (s1_vld),
        .s2_vld    (out_valid)
    );

    assign in_ready = adv;

    // ---- stage 1: horizontal blend on the upper and lower pairs ----
    logic signed [S0W-1:0] near_pix [2];
    logic signed [S0W-1:0] far_pix  [2];
    logic signed [S1W-1:0] row_res  [2];

    assign near_pix[0] = {1'b0, in_pix_a};
    assign far_pix[0]  = {1'b0, in_pix_b};
    assign near_pix[1] = {1'b0, in_pix_c};
    assign far_pix[1]  = {1'b0, in_pix_d};

    for (genvar g = 0; g < 2; g++) begin : g_row
        bilerp_lerp #(.DW(S0W), .FB(PU)) u_hlerp (
            .a    (near_pix[g]),
            .b    (far_pix[g]),
            .frac (in_ufrac),
            .y    (row_res[g])
        );
    end

    logic signed [S1W-1:0] s1_top, s1_bot;
    logic [PV-1:0]         s1_vf;
    logic                  s1_oob;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_top <= '0;
            s1_bot <= '0;
            s1_vf  <= '0;
            s1_oob <= 1'b0;
        end else if (adv) begin
            s1_top <= row_res[0];
            s1_bot <= row_res[1];
            s1_vf  <= in_vfrac;
            s1_oob <= in_oob;
        end
    end

    // ---- stage 2: vertical blend, clamp, out-of-range zeroing ----
    logic signed [S2W-1:0] col_res;
    logic [PIX_W-1:0]      clamped;

    bilerp_lerp #(.DW(S1W), .FB(PV)) u_vlerp (
        .a    (s1_top),
        .b    (s1_bot),
        .frac (s1_vf),
        .y    (col_res)
    );

    always_comb begin
        if (col_res[S2W-1])
            clamped = '0;
        else if (|col_res[S2W-2:PIX_W])
            clamped = '1;
        else
            clamped = col_res[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_pix <= '0;
        else if (adv)
            out_pix <= s1_oob ? '0 : clamped;
    end

    // ---- checks ----
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));
    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    // R7
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> s1_vld);
    // R7
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld && in_ready |=> out_valid);
    // R6
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld && s1_oob && in_ready |=> out_pix == '0);
endmodule

// File: tb/sim_bilerp_pipe.sv
`timescale 1ns/1ps
module sim_bilerp_pipe;
    localparam int PU = 8;
    localparam int PV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, in_oob = 1'b0;
    logic [7:0] pa = '0, pb = '0, pc = '0, pd = '0;
    logic [PU-1:0] uf = '0;
    logic [PV-1:0] vf = '0;
    logic out_valid, out_ready = 1'b1;
    logic [7:0] out_pix;

    always #2 clk = ~clk;

    bilerp_pipe #(.PIX_W(8), .PU(PU), .PV(PV)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix_a(pa), .in_pix_b(pb), .in_pix_c(pc), .in_pix_d(pd),
        .in_ufrac(uf), .in_vfrac(vf), .in_oob(in_oob),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    int total = 0, bad = 0, pops = 0;
    int exp_q[$];
    string tag_q[$];
    logic obs_ov;
    logic prev_stall = 1'b0;
    logic [7:0] prev_pix = '0;

    function automatic int ref_pix(int a, int b, int c, int d, int u, int v, bit ob);
        int t, w, p;
        t = a + (((b - a) * u) >>> PU);
        w = c + (((d - c) * u) >>> PU);
        p = t + (((w - t) * v) >>> PV);
        if (ob) return 0;
        if (p < 0) return 0;
        if (p > 255) return 255;
        return p;
    endfunction

    task automatic check(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One clock: drive at negedge, observe, then wait for the rising edge.
    task automatic cyc(bit iv, int a, int b, int c, int d, int u, int v,
                       bit ob, bit ordy, string tag);
        @(negedge clk);
        in_valid = iv; pa = 8'(a); pb = 8'(b); pc = 8'(c); pd = 8'(d);
        uf = PU'(u); vf = PV'(v); in_oob = ob; out_ready = ordy;
        #1;
        obs_ov = out_valid;
        if (prev_stall) begin
            check("R8 hold valid", int'(out_valid), 1);
            check("R8 hold pix", int'(out_pix), int'(prev_pix));
        end
        if (out_valid && !out_ready) check("R8 in_ready low", int'(in_ready), 0);
        prev_stall = out_valid && !out_ready;
        prev_pix = out_pix;
        if (in_valid && in_ready) begin
            exp_q.push_back(ref_pix(a, b, c, d, u, v, ob));
            tag_q.push_back(tag);
        end
        if (out_valid && out_ready) begin
            pops++;
            if (exp_q.size() == 0) check("R9 extra output", 1, 0);
            else check(tag_q.pop_front(), int'(out_pix), exp_q.pop_front());
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed, r;
        seed = 7;
        r = $urandom(seed);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset ready", int'(in_ready), 1);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        check("R1 after reset valid", int'(obs_ov), 0);

        // R7 latency: single beat into an empty pipe
        cyc(1, 10, 20, 30, 40, 0, 0, 0, 1, "R4 zero fracs");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        check("R7 not after one edge", int'(obs_ov), 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        check("R7 valid after two edges", int'(obs_ov), 1);
        idle(2);

        // directed corners
        cyc(1, 77, 0, 255, 3, 0, 0, 0, 1, "R4 pixel choice");
        cyc(1, 0, 255, 9, 9, 255, 0, 0, 1, "R2 ramp max frac");
        cyc(1, 200, 100, 50, 60, 128, 0, 0, 1, "R2 descending half");
        cyc(1, 1, 0, 1, 0, 1, 0, 0, 1, "R5 floor horizontal");
        cyc(1, 5, 5, 4, 4, 0, 1, 0, 1, "R5 floor vertical");
        cyc(1, 255, 255, 255, 255, 255, 255, 0, 1, "R3 saturated");
        cyc(1, 0, 100, 200, 50, 64, 192, 0, 1, "R3 mixed");
        cyc(1, 200, 201, 202, 203, 17, 99, 1, 1, "R6 out of range");
        idle(3);

        // R7 throughput: eight back-to-back beats
        begin
            int p0;
            p0 = pops;
            for (int i = 0; i < 8; i++)
                cyc(1, i * 30, 255 - i * 30, i * 7, i * 11, i * 32, 255 - i * 32, 0, 1, "R3 burst");
            idle(2);
            check("R7 burst count", pops - p0, 8);
        end

        // R8 directed stall
        cyc(1, 90, 10, 30, 70, 40, 200, 0, 1, "R3 stall beat");
        cyc(1, 11, 22, 33, 44, 100, 100, 0, 0, "R9 queued beat");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        idle(3);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit iv, ob, rd;
            iv = ($urandom % 10) < 7;
            ob = ($urandom % 10) == 0;
            rd = ($urandom % 4) != 0;
            cyc(iv, $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
                $urandom % 256, $urandom % 256, ob, rd, ob ? "R6 random" : "R3 random");
        end
        idle(4);
        check("R9 all results delivered", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule